// File: doc/BRIEF.md
# Rotating-Frame to Three-Phase Vector Transformer

This block converts a voltage vector given in the rotating (direct/quadrature) frame into three phase quantities spaced 120 degrees apart. A host writes a direct value, a quadrature value and a rotor angle into three operand registers, then pulses a start strobe. The block first rotates the vector by the angle into two stationary quadrature components, X and Y. It then splits these into three phases. The first phase is X itself, and the other two are mixes of X and Y. When the results are ready it raises a one-cycle completion pulse for an interrupt controller.

Sine and cosine of the angle come from an internal 256-entry quarter-wave table of magnitudes. Every data value is 12-bit two's complement with 11 fraction bits. Products are rounded to nearest and results saturate instead of wrapping. An operation always takes 8 cycles. While it runs, the operand registers are locked. A write that arrives in that window is dropped and reported on a one-cycle clash flag.

Top module: `vec_rotate_3ph`

## Requirements
- R1: During and after synchronous reset, busy, done_irq and wr_clash are 0, and ph_a, ph_b and ph_c read 0.
- R2: While the block is idle, a write with wr_sel = 0 loads the direct operand, wr_sel = 1 loads the quadrature operand and wr_sel = 2 loads the angle. wr_sel = 3 has no effect.
- R3: A start strobe seen at a clock edge while idle makes busy read 1 for exactly 8 cycles. In the cycle after busy falls, done_irq reads 1 for exactly one cycle, and busy is 0 in that cycle.
- R4: Let the table be T[i] = round(2047·sin((i+0.5)·π/512)) for i = 0 to 255. Let p be the angle's upper 10 bits, with quadrant p[9:8] and index i = p[7:0]. Sine and cosine are (T[i], T[255−i]) in quadrant 0, (T[255−i], −T[i]) in quadrant 1, (−T[i], −T[255−i]) in quadrant 2 and (−T[255−i], T[i]) in quadrant 3. Then X = sat(rnd(D·cos − Q·sin)) and Y = sat(rnd(D·sin + Q·cos)).
- R5: ph_a equals X.
- R6: ph_b = sat(rnd(−1024·X + 1774·Y)) and ph_c = sat(rnd(−1024·X − 1774·Y)). Here rnd(v) = floor((v + 1024) / 2048).
- R7: Every result saturates to the range −2048 to 2047 and never wraps.
- R8: A write while busy leaves the operands unchanged. The cycle after it, wr_clash reads 1 for one cycle.
- R9: A start strobe while busy is ignored. No second operation follows.
- R10: ph_a, ph_b and ph_c change only in the cycle in which done_irq is 1. Otherwise they hold.
- R11: A write in the same cycle as an accepted start takes effect for that operation.
- R12: The two lowest angle bits do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 2 | Operand select: 0 direct, 1 quadrature, 2 angle |
| wr_data | input | 12 | Operand write data |
| start | input | 1 | Start strobe |
| busy | output | 1 | Operation in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| wr_clash | output | 1 | One-cycle flag for a write dropped while busy |
| ph_a | output | 12 | Phase 1 result (signed) |
| ph_b | output | 12 | Phase 2 result (signed) |
| ph_c | output | 12 | Phase 3 result (signed) |

## Verification
The bench covers angles in all four quadrants. A wrong sign or a wrong table index in one quadrant would flip or mirror the phase results there. It drives full-scale operands whose rotated sum goes past 2047 or below −2048. A design that wraps would return a value of the opposite sign. It writes during busy, starts during busy, and writes in the start cycle. A design without the operand lock would mix old and new operands. A design that accepts the repeated start would run a second operation. A design that samples operands too early or too late would miss the write made in the start cycle.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_QUAD = 2'd1,
    SEL_ANG  = 2'd2
  } vr_sel_e;

  localparam int VR_LATENCY = 8;
endpackage

// File: rtl/vr_trig_rom.sv
module vr_trig_rom #(
  parameter int DW = 12,
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rd_en,
  input  logic                 sgn_en,
  input  logic [AW+1:0]        phase,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  localparam int    DEPTH = 1 << AW;
  localparam real   FS    = (2.0 ** (DW - 1)) - 1.0;
  localparam real   PI    = 3.14159265358979;

  logic [DW-2:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = (DW-1)'($rtoi(FS * $sin((i + 0.5) * PI / (2.0 * DEPTH)) + 0.5));
  end

  logic [1:0]    quad_in, quad_r;
  logic [AW-1:0] idx, idx_s, idx_c;
  logic [DW-2:0] mag_s, mag_c;

  assign quad_in = phase[AW+1:AW];
  assign idx     = phase[AW-1:0];
  assign idx_s   = quad_in[0] ? ~idx : idx;
  assign idx_c   = quad_in[0] ? idx : ~idx;

  always_ff @(posedge clk) begin
    if (rd_en) begin
      mag_s  <= rom[idx_s];
      mag_c  <= rom[idx_c];
      quad_r <= quad_in;
    end
  end

  always_ff @(posedge clk) begin
    if (sgn_en) begin
      sin_o <= quad_r[1] ? -$signed({1'b0, mag_s}) : $signed({1'b0, mag_s});
      cos_o <= (quad_r[1] ^ quad_r[0]) ? -$signed({1'b0, mag_c}) : $signed({1'b0, mag_c});
    end
  end
endmodule

// File: rtl/vr_park.sv
module vr_park #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 mul_en,
  input  logic                 sum_en,
  input  logic signed [DW-1:0] d_in,
  input  logic signed [DW-1:0] q_in,
  input  logic signed [DW-1:0] sin_in,
  input  logic signed [DW-1:0] cos_in,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o
);
  localparam int SW = 2 * DW + 1;
  localparam logic signed [SW-1:0] HALF = SW'(1 << (DW - 2));
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] r;
    r = (v + HALF) >>> (DW - 1);
    if (r > MAXV) return MAXV[DW-1:0];
    if (r < MINV) return MINV[DW-1:0];
    return r[DW-1:0];
  endfunction

  logic signed [2*DW-1:0] p_dc, p_qs, p_ds, p_qc;

  always_ff @(posedge clk) begin
    if (mul_en) begin
      p_dc <= d_in * cos_in;
      p_qs <= q_in * sin_in;
      p_ds <= d_in * sin_in;
      p_qc <= q_in * cos_in;
    end
    if (sum_en) begin
      x_o <= rnd_sat(SW'(p_dc) - SW'(p_qs));
      y_o <= rnd_sat(SW'(p_ds) + SW'(p_qc));
    end
  end
endmodule

// File: rtl/vr_clarke.sv
module vr_clarke #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 mul_en,
  input  logic                 sum_en,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  output logic signed [DW-1:0] b_o,
  output logic signed [DW-1:0] c_o
);
  localparam int SW = 2 * DW + 1;
  localparam int K  = $rtoi(0.8660254037844386 * (2.0 ** (DW - 1)) + 0.5);
  localparam logic signed [SW-1:0] HALF = SW'(1 << (DW - 2));
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);
  localparam logic signed [SW-1:0] KS   = SW'(K);

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] r;
    r = (v + HALF) >>> (DW - 1);
    if (r > MAXV) return MAXV[DW-1:0];
    if (r < MINV) return MINV[DW-1:0];
    return r[DW-1:0];
  endfunction

  logic signed [SW-1:0] px, py;

  always_ff @(posedge clk) begin
    if (mul_en) begin
      px <= SW'(x_in) <<< (DW - 2);
      py <= SW'(y_in) * KS;
    end
    if (sum_en) begin
      b_o <= rnd_sat(py - px);
      c_o <= rnd_sat(-px - py);
    end
  end
endmodule

// File: rtl/vec_rotate_3ph.sv
module vec_rotate_3ph #(
  parameter int DW = 12,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  output logic          busy,
  output logic          done_irq,
  output logic          wr_clash,
  output logic [DW-1:0] ph_a,
  output logic [DW-1:0] ph_b,
  output logic [DW-1:0] ph_c
);
  import vr_pkg::*;

  localparam int PW  = AW + 2;
  localparam int LAT = VR_LATENCY;
  localparam int CW  = $clog2(LAT + 1);

  logic signed [DW-1:0] d_r, q_r;
  logic [PW-1:0]        ang_r;
  logic [CW-1:0]        cnt;
  logic signed [DW-1:0] s_w, c_w, x_w, y_w, b_w, cc_w;

  // operand registers, locked while busy
  always_ff @(posedge clk) begin
    if (rst) begin
      d_r      <= '0;
      q_r      <= '0;
      ang_r    <= '0;
      wr_clash <= 1'b0;
    end else begin
      wr_clash <= wr_en && busy;
      if (wr_en && !busy) begin
        if (wr_sel == 2'(SEL_DIR))  d_r   <= wr_data;
        if (wr_sel == 2'(SEL_QUAD)) q_r   <= wr_data;
        if (wr_sel == 2'(SEL_ANG))  ang_r <= wr_data[DW-1 -: PW];
      end
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      busy     <= 1'b0;
      done_irq <= 1'b0;
      ph_a     <= '0;
      ph_b     <= '0;
      ph_c     <= '0;
    end else begin
      done_irq <= 1'b0;
      if (busy) begin
        if (cnt == CW'(LAT)) begin
          cnt      <= '0;
          busy     <= 1'b0;
          done_irq <= 1'b1;
          ph_a     <= x_w;
          ph_b     <= b_w;
          ph_c     <= cc_w;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else if (start) begin
        cnt  <= CW'(1);
        busy <= 1'b1;
      end
    end
  end

  vr_trig_rom #(.DW(DW), .AW(AW)) u_rom (
    .clk   (clk),
    .rd_en (busy && cnt == CW'(1)),
    .sgn_en(busy && cnt == CW'(2)),
    .phase (ang_r),
    .sin_o (s_w),
    .cos_o (c_w)
  );

  vr_park #(.DW(DW)) u_park (
    .clk   (clk),
    .mul_en(busy && cnt == CW'(3)),
    .sum_en(busy && cnt == CW'(4)),
    .d_in  (d_r),
    .q_in  (q_r),
    .sin_in(s_w),
    .cos_in(c_w),
    .x_o   (x_w),
    .y_o   (y_w)
  );

  vr_clarke #(.DW(DW)) u_clarke (
    .clk   (clk),
    .mul_en(busy && cnt == CW'(5)),
    .sum_en(busy && cnt == CW'(6)),
    .x_in  (x_w),
    .y_in  (y_w),
    .b_o   (b_w),
    .c_o   (cc_w)
  );
endmodule

// File: rtl/vr_checker.sv
module vr_checker #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          start,
  input logic          busy,
  input logic          done_irq,
  input logic          wr_clash,
  input logic [DW-1:0] ph_a,
  input logic [DW-1:0] ph_b,
  input logic [DW-1:0] ph_c
);
  logic [7:0] blen;

  always_ff @(posedge clk) begin
    if (rst)       blen <= '0;
    else if (busy) blen <= blen + 8'd1;
    else           blen <= '0;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (blen == 8'd8));

  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> ($past(busy) && !busy));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  assert_clash_cause_R8: assert property (@(posedge clk) disable iff (rst)
    wr_clash |-> $past(wr_en && busy));

  assert_clash_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> wr_clash);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done_irq |-> ($stable(ph_a) && $stable(ph_b) && $stable(ph_c)));
endmodule

bind vec_rotate_3ph vr_checker #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .start   (start),
  .busy    (busy),
  .done_irq(done_irq),
  .wr_clash(wr_clash),
  .ph_a    (ph_a),
  .ph_b    (ph_b),
  .ph_c    (ph_c)
);

// File: tb/sim_vec_rotate_3ph.sv
module sim_vec_rotate_3ph;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [11:0] wr_data = 12'd0;
  logic        start = 1'b0;
  logic        busy, done_irq, wr_clash;
  logic [11:0] ph_a, ph_b, ph_c;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  vec_rotate_3ph u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .busy(busy), .done_irq(done_irq), .wr_clash(wr_clash),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c)
  );

  // ---- behavioural reference ----
  function automatic int tbl(int i);
    return $rtoi(2047.0 * $sin((i + 0.5) * 3.14159265358979 / 512.0) + 0.5);
  endfunction
  function automatic int rnd(int v);
    return (v + 1024) >>> 11;
  endfunction
  function automatic int sat(int v);
    return (v > 2047) ? 2047 : (v < -2048) ? -2048 : v;
  endfunction
  function automatic void calc(int d, int q, int ang, output int a, output int b, output int c);
    int p, qd, i, s, co, x, y;
    p  = ang >> 2;
    qd = p >> 8;
    i  = p & 255;
    s  = tbl((qd % 2) ? 255 - i : i);
    co = tbl((qd % 2) ? i : 255 - i);
    if (qd >= 2) s = -s;
    if (qd == 1 || qd == 2) co = -co;
    x = sat(rnd(d * co - q * s));
    y = sat(rnd(d * s + q * co));
    a = x;
    b = sat(rnd(-1024 * x + 1774 * y));
    c = sat(rnd(-1024 * x - 1774 * y));
  endfunction

  int m_d, m_q, m_ang, m_cnt, m_a, m_b, m_c, p_a, p_b, p_c;
  bit m_done, m_clash;

  always @(posedge clk) begin
    if (rst) begin
      m_d = 0; m_q = 0; m_ang = 0; m_cnt = 0;
      m_a = 0; m_b = 0; m_c = 0; m_done = 0; m_clash = 0;
    end else begin
      bit was_busy;
      was_busy = (m_cnt != 0);
      m_done  = 0;
      m_clash = wr_en && was_busy;
      if (!was_busy && wr_en) begin
        if (wr_sel == 2'd0) m_d   = int'($signed(wr_data));
        if (wr_sel == 2'd1) m_q   = int'($signed(wr_data));
        if (wr_sel == 2'd2) m_ang = int'(wr_data);
      end
      if (was_busy) begin
        if (m_cnt == 8) begin
          m_cnt = 0; m_done = 1; m_a = p_a; m_b = p_b; m_c = p_c;
        end else m_cnt++;
      end else if (start) begin
        m_cnt = 1;
        calc(m_d, m_q, m_ang, p_a, p_b, p_c);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("R3 busy", int'(busy), int'(m_cnt != 0));
      chk("R3 done_irq", int'(done_irq), int'(m_done));
      chk("R8 wr_clash", int'(wr_clash), int'(m_clash));
      chk("R5 R10 ph_a", int'($signed(ph_a)), m_a);
      chk("R6 R10 ph_b", int'($signed(ph_b)), m_b);
      chk("R6 R10 ph_c", int'($signed(ph_c)), m_c);
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 12'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic go();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    repeat (11) @(negedge clk);
  endtask

  task automatic run(int d, int q, int ang);
    wr(2'd0, d); wr(2'd1, q); wr(2'd2, ang);
    go();
    settle();
  endtask

  initial begin
    int ea, eb, ec, sa;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done_irq", int'(done_irq), 0);
    chk("R1 ph_a", int'(ph_a), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 wr_clash", int'(wr_clash), 0);
    chk("R1 ph_c", int'(ph_c), 0);

    // R2: operand mapping, quadrant 0
    run(1000, 0, 0);
    chk("R2 ph_a", int'($signed(ph_a)), 1000);
    calc(1000, 0, 0, ea, eb, ec);
    chk("R4 ph_b", int'($signed(ph_b)), eb);

    // R2: select 3 does nothing
    wr(2'd3, 12'h7FF);
    go(); settle();
    chk("R2 sel3 ignored", int'($signed(ph_a)), 1000);

    // R4/R12: all quadrants
    for (int k = 0; k < 4; k++) begin
      run(700, -300, k * 1024 + 300);
      calc(700, -300, k * 1024 + 300, ea, eb, ec);
      chk("R4 quadrant ph_a", int'($signed(ph_a)), ea);
      chk("R4 quadrant ph_c", int'($signed(ph_c)), ec);
    end

    // R12: low angle bits ignored
    run(1500, 400, 12'h401);
    sa = int'($signed(ph_b));
    run(1500, 400, 12'h402);
    chk("R12 low bits", int'($signed(ph_b)), sa);

    // R7: saturation both directions
    run(2047, -2048, 12'h200);
    chk("R7 ph_a high", int'($signed(ph_a)), 2047);
    run(-2048, 2047, 12'h200);
    chk("R7 ph_a low", int'($signed(ph_a)), -2048);

    // R8: write while busy dropped
    wr(2'd0, 800); wr(2'd1, 100); wr(2'd2, 12'h155);
    go();
    wr(2'd0, 5);
    settle();
    go(); settle();
    calc(800, 100, 12'h155, ea, eb, ec);
    chk("R8 operand kept", int'($signed(ph_a)), ea);

    // R9: start while busy ignored
    go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (14) @(negedge clk);
    chk("R9 no second run", int'(busy), 0);

    // R11: write in the start cycle takes effect
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 12'(-1200); start = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; start = 1'b0;
    settle();
    calc(-1200, 100, 12'h155, ea, eb, ec);
    chk("R11 ph_a", int'($signed(ph_a)), ea);

    // mixed operands
    for (int k = 0; k < 40; k++) begin
      int d, q, an;
      d  = int'($urandom_range(0, 4095)) - 2048;
      q  = int'($urandom_range(0, 4095)) - 2048;
      an = int'($urandom_range(0, 4095));
      run(d, q, an);
      calc(d, q, an, ea, eb, ec);
      chk("R4 R6 mixed ph_b", int'($signed(ph_b)), eb);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule